// File: doc/BRIEF.md
# Keyed Register Write-Protection Controller

This block stands in front of a peripheral's register file and decides, for each bus write, whether the write may reach its target. It owns one 32-bit control register. That register holds a general protect enable, two protect enables that each cover one register group (CRC and filter), and a lock bit that can only be set. Software can change the control register only by putting a fixed 24-bit unlock key in the upper bits of the write data. After the lock bit is set, the register stays frozen until the next hardware reset.

Every guarded register has a fixed attribute that a parameter table supplies by address: a protect mark and a group (general, CRC or filter). A write from a non-debugger master to a marked register is refused when the enable for that register's group is set. A refused write is not forwarded and its response carries an error. Writes from a debugger always pass. Writes from a security-module master count as ordinary non-debugger writes. Reads are never refused. Each request gets one registered response in the cycle after it is accepted, and an allowed write to a guarded address is forwarded to the register file in that same cycle.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the control register reads 0, and `rsp_valid` and `fwd_we` are low until a request arrives.
- R2: A write to the control register address (default 0x70) with `req_wdata[31:8]` equal to the unlock key (default 0xA5C396) is accepted while the register is unlocked. It loads bit 0 (general enable), bit 2 (CRC enable) and bit 3 (filter enable) from the write data and sets bit 1 (lock) when `req_wdata[1]` is 1. The response has no error.
- R3: A control register write whose key differs from the unlock key returns an error and leaves every bit of the control register unchanged.
- R4: A read of the control register returns the four control bits in positions 3..0 and zero in bits 31:4, including the key field.
- R5: Once the lock bit is set, it stays set. Every later write to the control register, from any master and with any key, returns an error and changes nothing until a hardware reset.
- R6: A non-debugger write to a protect-marked register of the general group returns an error and is not forwarded when bit 0 is set. It is forwarded without error when bit 0 is clear.
- R7: For a protect-marked register of the CRC group, only bit 2 decides whether a non-debugger write is refused. Bit 0 has no effect on it.
- R8: For a protect-marked register of the filter group, only bit 3 decides whether a non-debugger write is refused.
- R9: A write with `req_dbg` high to any guarded address is forwarded without error, whatever the enables are.
- R10: A write to an address that is not protect-marked, or that is absent from the attribute table, is always forwarded without error.
- R11: A read never returns an error. A read of any address other than the control register returns 0.
- R12: Each accepted request produces exactly one `rsp_valid` pulse in the following cycle. An allowed guarded write raises `fwd_we` in that same cycle, with the request's address on `fwd_addr` and its data on `fwd_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dbg | input | 1 | The request comes from a debugger master |
| req_addr | input | ADDR_W | Byte offset of the target register |
| req_wdata | input | 32 | Write data; bits 31:8 carry the key for control writes |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_err | output | 1 | The write was refused (slave error) |
| rsp_rdata | output | 32 | Read data (control register or 0) |
| fwd_we | output | 1 | Write strobe to the guarded register file |
| fwd_addr | output | ADDR_W | Address of the forwarded write |
| fwd_wdata | output | 32 | Data of the forwarded write |

## Verification
The state that matters here is four control bits. A bad bit does not show up on its own. It shows up the next time something touches it: a read of the control register exposes it on `rsp_rdata` in the following cycle, and a write to a guarded register exposes it as a wrong `rsp_err`/`fwd_we` pair in the following cycle. To cover this, the stimulus reads the control register back after every configuration change. It also writes one register of each group under each enable pattern, so that a swapped enable or a lost lock shows within a few requests. Re-reading the register after refused writes shows any partial update that a refused write caused.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned KEY_LSB = 8;
  localparam int unsigned KEY_W   = DATA_W - KEY_LSB;

  typedef enum logic [1:0] {
    GRP_GEN = 2'd0,
    GRP_CRC = 2'd1,
    GRP_FLT = 2'd2
  } wp_group_e;

  // attribute entry: {marked, group}
  typedef struct packed {
    logic      marked;
    wp_group_e group;
  } wp_attr_t;

  localparam int unsigned ATTR_W = $bits(wp_attr_t);

  // control bits, bit 3 down to bit 0 of the register
  typedef struct packed {
    logic flt_en;
    logic crc_en;
    logic lock;
    logic gen_en;
  } wp_cfg_t;

  localparam int unsigned CFG_W = $bits(wp_cfg_t);

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/wprot_attr_lookup.sv
module wprot_attr_lookup
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_GUARD = 4,
  parameter logic [NUM_GUARD*ADDR_W-1:0] GUARD_ADDRS = '0,
  parameter logic [NUM_GUARD*ATTR_W-1:0] GUARD_ATTRS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output wp_attr_t          attr
);

  logic [NUM_GUARD-1:0] hit;
  wp_attr_t             entry [NUM_GUARD];

  for (genvar g = 0; g < NUM_GUARD; g++) begin : g_entry
    assign hit[g]   = (addr == GUARD_ADDRS[g*ADDR_W +: ADDR_W]);
    assign entry[g] = wp_attr_t'(GUARD_ATTRS[g*ATTR_W +: ATTR_W]);
  end

  // lowest-index match wins; a miss means unmarked, general group
  always_comb begin
    attr = '{marked: 1'b0, group: GRP_GEN};
    for (int i = NUM_GUARD - 1; i >= 0; i--) begin
      if (hit[i]) attr = entry[i];
    end
  end

endmodule

// File: rtl/wprot_cfg_reg.sv
module wprot_cfg_reg
  import wprot_pkg::*;
#(
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 24'hA5C396
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  output wp_cfg_t           cfg,
  output logic              wr_reject
);

  wp_cfg_t cfg_q, cfg_d;
  logic    key_ok;
  logic    cfg_ld;

  assign key_ok    = (wdata[DATA_W-1:KEY_LSB] == UNLOCK_KEY);
  assign wr_reject = wr_req && (!key_ok || cfg_q.lock);
  assign cfg_ld    = wr_req && !wr_reject;

  always_comb begin
    cfg_d        = cfg_q;
    cfg_d.gen_en = wdata[0];
    cfg_d.lock   = cfg_q.lock | wdata[1];
    cfg_d.crc_en = wdata[2];
    cfg_d.flt_en = wdata[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wprot_pkg::*;
(
  input  logic     is_write,
  input  logic     is_ctrl,
  input  logic     dbg,
  input  wp_attr_t attr,
  input  wp_cfg_t  cfg,
  input  logic     ctrl_reject,
  output logic     deny
);

  logic grp_en;
  logic guard_deny;

  always_comb begin
    unique case (attr.group)
      GRP_CRC: grp_en = cfg.crc_en;
      GRP_FLT: grp_en = cfg.flt_en;
      default: grp_en = cfg.gen_en;
    endcase
  end

  assign guard_deny = is_write && attr.marked && !dbg && grp_en;
  assign deny       = is_ctrl ? ctrl_reject : guard_deny;

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h70,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 24'hA5C396,
  parameter int unsigned NUM_GUARD  = 4,
  parameter logic [NUM_GUARD*ADDR_W-1:0] GUARD_ADDRS = {8'h20, 8'h10, 8'h04, 8'h00},
  parameter logic [NUM_GUARD*ATTR_W-1:0] GUARD_ATTRS = {3'b110, 3'b101, 3'b000, 3'b100}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dbg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fwd_we,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata
);

  logic     rst_sync_n;
  logic     is_ctrl;
  logic     wr_any;
  logic     ctrl_wr;
  logic     ctrl_reject;
  logic     deny;
  wp_attr_t attr;
  wp_cfg_t  cfg;

  logic              rsp_valid_d, rsp_err_d, fwd_we_d;
  logic [DATA_W-1:0] rdata_d;
  logic              rsp_valid_q, rsp_err_q, fwd_we_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] fwd_addr_q;
  logic [DATA_W-1:0] fwd_wdata_q;
  logic              fwd_ld;

  wprot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign is_ctrl = (req_addr == CTRL_ADDR);
  assign wr_any  = req_valid && req_write;
  assign ctrl_wr = wr_any && is_ctrl;

  wprot_attr_lookup #(
    .ADDR_W      (ADDR_W),
    .NUM_GUARD   (NUM_GUARD),
    .GUARD_ADDRS (GUARD_ADDRS),
    .GUARD_ATTRS (GUARD_ATTRS)
  ) u_lookup (
    .addr (req_addr),
    .attr (attr)
  );

  wprot_cfg_reg #(
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_req    (ctrl_wr),
    .wdata     (req_wdata),
    .cfg       (cfg),
    .wr_reject (ctrl_reject)
  );

  wprot_decide u_decide (
    .is_write    (wr_any),
    .is_ctrl     (is_ctrl),
    .dbg         (req_dbg),
    .attr        (attr),
    .cfg         (cfg),
    .ctrl_reject (ctrl_reject),
    .deny        (deny)
  );

  // next-state for the response stage
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = wr_any && deny;
    fwd_we_d    = wr_any && !is_ctrl && !deny;
    rdata_d     = '0;
    if (req_valid && !req_write && is_ctrl) begin
      rdata_d = {{(DATA_W-CFG_W){1'b0}}, cfg};
    end
  end

  assign fwd_ld = wr_any && !is_ctrl;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      fwd_we_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      fwd_we_q    <= fwd_we_d;
      rdata_q     <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fwd_addr_q  <= '0;
      fwd_wdata_q <= '0;
    end else if (fwd_ld) begin
      fwd_addr_q  <= req_addr;
      fwd_wdata_q <= req_wdata;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rdata_q;
  assign fwd_we    = fwd_we_q;
  assign fwd_addr  = fwd_addr_q;
  assign fwd_wdata = fwd_wdata_q;

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk
  import wprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h70,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 24'hA5C396
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_dbg,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              fwd_we,
  input logic [CFG_W-1:0]  cfg_bits
);

  logic ctrl_wr;
  assign ctrl_wr = req_valid && req_write && (req_addr == CTRL_ADDR);

  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  p_fwd_only_ok_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fwd_we |-> (rsp_valid && !rsp_err));

  p_read_no_err_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_write) |=> !rsp_err);

  p_bad_key_err_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr && (req_wdata[DATA_W-1:KEY_LSB] != UNLOCK_KEY)) |=> rsp_err);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_wr |=> $stable(cfg_bits));

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_bits[1] |=> cfg_bits[1]);

  p_locked_write_err_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr && cfg_bits[1]) |=> (rsp_err && $stable(cfg_bits)));

  p_dbg_pass_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && req_dbg && (req_addr != CTRL_ADDR)) |=> (fwd_we && !rsp_err));

endmodule

bind wprot_ctrl wprot_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .CTRL_ADDR  (CTRL_ADDR),
  .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_dbg    (req_dbg),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .fwd_we     (fwd_we),
  .cfg_bits   (cfg)
);

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;

  localparam logic [23:0] KEY  = 24'hA5C396;
  localparam logic [7:0]  CTRL = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dbg = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, fwd_we;
  logic [31:0] rsp_rdata, fwd_wdata;
  logic [7:0]  fwd_addr;

  always #5 clk = ~clk;

  wprot_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_dbg(req_dbg),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata)
  );

  typedef struct {
    logic        err;
    logic [31:0] rdata;
    logic        fwd;
    logic [7:0]  faddr;
    logic [31:0] fdata;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          vectors = 0;
  int          miscompares = 0;
  logic        quiet = 1'b1;
  logic        done = 1'b0;
  logic [3:0]  m_cfg = 4'h0;   // {flt, crc, lock, gen}

  task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // monitor: pops one expectation per response
  always @(posedge clk) begin
    #2;
    if (!quiet) begin
      if (sb.size() == 0) begin
        if (rsp_valid || fwd_we) begin
          vectors++;
          fail("R12", "unexpected response", {30'b0, rsp_valid, fwd_we}, 32'h0);
        end
      end else begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if (rsp_valid !== 1'b1) fail(e.tag, "rsp_valid", {31'b0, rsp_valid}, 32'h1);
        else if (rsp_err !== e.err) fail(e.tag, "rsp_err", {31'b0, rsp_err}, {31'b0, e.err});
        else if (rsp_rdata !== e.rdata) fail(e.tag, "rsp_rdata", rsp_rdata, e.rdata);
        else if (fwd_we !== e.fwd) fail(e.tag, "fwd_we", {31'b0, fwd_we}, {31'b0, e.fwd});
        else if (e.fwd && fwd_addr !== e.faddr) fail(e.tag, "fwd_addr", {24'b0, fwd_addr}, {24'b0, e.faddr});
        else if (e.fwd && fwd_wdata !== e.fdata) fail(e.tag, "fwd_wdata", fwd_wdata, e.fdata);
      end
    end
  end

  function automatic logic [2:0] attr_of(input logic [7:0] a);
    // {marked, group}: group 0 general, 1 CRC, 2 filter
    case (a)
      8'h00:   return 3'b100;
      8'h10:   return 3'b101;
      8'h20:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  // driver: one request per call, back to back across calls
  task automatic issue(input logic wr, input logic dbg, input logic [7:0] a,
                       input logic [31:0] d, input string tag);
    exp_t e;
    logic [2:0] at;
    logic en;
    e.tag = tag; e.err = 1'b0; e.rdata = '0; e.fwd = 1'b0; e.faddr = a; e.fdata = d;
    if (a == CTRL) begin
      if (wr) begin
        if (d[31:8] != KEY || m_cfg[1]) e.err = 1'b1;
        else m_cfg = {d[3], d[2], m_cfg[1] | d[1], d[0]};
      end else e.rdata = {28'b0, m_cfg};
    end else if (wr) begin
      at = attr_of(a);
      en = (at[1:0] == 2'd1) ? m_cfg[2] : (at[1:0] == 2'd2) ? m_cfg[3] : m_cfg[0];
      e.err = at[2] && !dbg && en;
      e.fwd = !e.err;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dbg = dbg; req_addr = a; req_wdata = d;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_dbg = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    quiet = 1'b1;
    req_valid = 1'b0;
    rst_n = 1'b0;
    m_cfg = 4'h0;
    sb.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || fwd_we !== 1'b0)
      fail("R1", "idle outputs after reset", {30'b0, rsp_valid, fwd_we}, 32'h0);
    quiet = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    issue(1'b0, 1'b0, CTRL, 32'h0, "R1 reset readback");
    // bad key, nothing may change
    issue(1'b1, 1'b0, CTRL, {24'h123456, 8'h0F}, "R3 bad key");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R3 readback after bad key");
    // all enables off: everything forwards
    issue(1'b1, 1'b0, 8'h00, 32'hAAAA0001, "R6 general off");
    issue(1'b1, 1'b0, 8'h10, 32'hAAAA0002, "R7 crc off");
    issue(1'b1, 1'b0, 8'h20, 32'hAAAA0003, "R8 filter off");
    // general enable with junk in bits 7:4
    issue(1'b1, 1'b0, CTRL, {KEY, 8'hF1}, "R2 set general");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R4 readback masks high bits");
    issue(1'b1, 1'b0, 8'h00, 32'hBBBB0001, "R6 general on refuses");
    issue(1'b1, 1'b0, 8'h10, 32'hBBBB0002, "R7 general does not cover crc");
    issue(1'b1, 1'b0, 8'h20, 32'hBBBB0003, "R8 general does not cover filter");
    issue(1'b1, 1'b0, 8'h04, 32'hBBBB0004, "R10 unmarked");
    issue(1'b1, 1'b0, 8'h44, 32'hBBBB0005, "R10 unlisted");
    issue(1'b1, 1'b1, 8'h00, 32'hBBBB0006, "R9 debugger bypass general");
    issue(1'b0, 1'b0, 8'h00, 32'h0, "R11 read of protected reg");
    // group enables only
    issue(1'b1, 1'b0, CTRL, {KEY, 8'h0C}, "R2 set crc and filter");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R2 readback");
    issue(1'b1, 1'b0, 8'h10, 32'hCCCC0001, "R7 crc refuses");
    issue(1'b1, 1'b0, 8'h20, 32'hCCCC0002, "R8 filter refuses");
    issue(1'b1, 1'b0, 8'h00, 32'hCCCC0003, "R6 general cleared forwards");
    issue(1'b1, 1'b1, 8'h10, 32'hCCCC0004, "R9 debugger bypass crc");
    issue(1'b1, 1'b1, 8'h20, 32'hCCCC0005, "R9 debugger bypass filter");
    issue(1'b0, 1'b0, 8'h20, 32'h0, "R11 read of filter reg");
    idle(2);
    // lock
    issue(1'b1, 1'b0, CTRL, {KEY, 8'h06}, "R2 set crc and lock");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R5 readback locked");
    issue(1'b1, 1'b0, CTRL, {KEY, 8'h00}, "R5 good key refused when locked");
    issue(1'b1, 1'b1, CTRL, {KEY, 8'h09}, "R5 debugger refused when locked");
    issue(1'b1, 1'b0, CTRL, {24'h0, 8'h00}, "R5 bad key when locked");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R5 state unchanged");
    issue(1'b1, 1'b0, 8'h10, 32'hDDDD0001, "R7 crc still protected");
    issue(1'b1, 1'b0, 8'h20, 32'hDDDD0002, "R8 filter off forwards");
    idle(3);
    // hardware reset clears the lock
    do_reset();
    issue(1'b0, 1'b0, CTRL, 32'h0, "R5 reset clears lock");
    issue(1'b1, 1'b0, CTRL, {KEY, 8'h08}, "R5 writable after reset");
    issue(1'b0, 1'b0, CTRL, 32'h0, "R8 readback filter only");
    issue(1'b1, 1'b0, 8'h20, 32'hEEEE0001, "R8 filter on refuses");
    issue(1'b1, 1'b0, 8'h10, 32'hEEEE0002, "R7 crc off forwards");
    idle(4);
    vectors++;
    if (sb.size() != 0) fail("R12", "missing responses", sb.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule